// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block steps the program counter of a small 8-bit controller core whose program memory is split into 512-word pages. Each cycle it takes one decoded strobe from the instruction decoder: step, long jump, subroutine call, write of the low PC byte, or return-with-literal. It forms the next address from the instruction's address field and the page-select bits held in the status register. A two-entry return stack, as wide as the PC, holds the return addresses for calls.

A plain step that leaves the last word of a page simply carries into the next page. Jumps, calls and low-byte writes always take their page from the page-select input and not from the current PC, so software must keep that input up to date. A return restores the full address from the stack. It also hands the instruction's literal to the working register through a one-cycle load strobe.

Top module: `pc_seq`

## Requirements
- R1: A synchronous reset sets the PC to all ones (the reset vector), clears both stack entries to zero and holds the W-load strobe low.
- R2: A step strobe loads PC+1. It carries across page boundaries (for example 0x1FF to 0x200), and from the all-ones address it wraps to zero.
- R3: A jump strobe loads the PC with the page-select bits in the bits above bit 8 and the 9-bit address field in bits 8 to 0.
- R4: A call strobe copies stack entry 1 into entry 2 and writes PC+1 into entry 1. It loads the PC with the page-select bits above bit 8, a zero in bit 8 and address field bits 7 to 0 in bits 7 to 0.
- R5: A low-byte write strobe loads the PC with the same target as a call and leaves the stack untouched.
- R6: A return strobe loads the PC from stack entry 1 and copies entry 2 into entry 1, leaving entry 2 as it was. Further returns therefore keep producing the old entry-2 address.
- R7: In the cycle after a return, the W-load strobe is high and the W value equals the 8-bit literal. In the cycle after any other input, the W-load strobe is low.
- R8: With three nested calls, only the two most recent return addresses survive. The oldest is lost.
- R9: With no strobe active, the PC holds its value.
- R10: Reset takes priority over any strobe in the same cycle.
- R11: The PC width is a parameter of 10 or 11 bits, and the page-select field is the width minus 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc | input | 1 | Step strobe |
| jmp | input | 1 | Long jump strobe |
| call | input | 1 | Subroutine call strobe |
| pcl_wr | input | 1 | Low PC byte write strobe |
| ret | input | 1 | Return-with-literal strobe |
| addr | input | 9 | Instruction address field (call and low-byte write use bits 7:0) |
| lit | input | 8 | Instruction literal for the return |
| page_sel | input | PC_W-9 | Page-select bits from the status register |
| pc | output | PC_W | Current program counter |
| w_val | output | 8 | Value to load into the working register |
| w_load | output | 1 | W-register load strobe, one cycle after a return |

## Verification
Two actions can fall in the same cycle. A call shifts stack entry 1 down into entry 2 while it pushes PC+1 and redirects the PC, and a return promotes entry 2 while it restores the PC. The bench stacks three calls and then issues three returns, and it also runs long mixed sequences in which calls and returns arrive back to back. Each result is compared with a bench model of the PC and both entries. Reset is also raised in the same cycle as a call, and the check expects the reset vector, no W load, and an empty stack on the next return.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PC_W = 11,
  localparam int PG_W = PC_W - 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            jmp,
  input  logic            call,
  input  logic            pcl_wr,
  input  logic            ret,
  input  logic [8:0]      addr,
  input  logic [7:0]      lit,
  input  logic [PG_W-1:0] page_sel,
  output logic [PC_W-1:0] pc,
  output logic [7:0]      w_val,
  output logic            w_load
);
  logic [PC_W-1:0] lvl1, lvl2;

  wire [PC_W-1:0] pc_inc   = pc + {{(PC_W-1){1'b0}}, 1'b1};
  wire [PC_W-1:0] far_tgt  = {page_sel, addr};
  wire [PC_W-1:0] near_tgt = {page_sel, 1'b0, addr[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '1;
      lvl1   <= '0;
      lvl2   <= '0;
      w_val  <= '0;
      w_load <= 1'b0;
    end else begin
      w_load <= ret;
      if (ret) w_val <= lit;
      if (inc)
        pc <= pc_inc;
      else if (jmp)
        pc <= far_tgt;
      else if (call) begin
        lvl2 <= lvl1;
        lvl1 <= pc_inc;
        pc   <= near_tgt;
      end else if (pcl_wr)
        pc <= near_tgt;
      else if (ret) begin
        pc   <= lvl1;
        lvl1 <= lvl2;
      end
    end
  end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W = 11,
  localparam int PG_W = PC_W - 9
) (
  input logic            clk,
  input logic            rst,
  input logic            inc,
  input logic            jmp,
  input logic            call,
  input logic            pcl_wr,
  input logic            ret,
  input logic [8:0]      addr,
  input logic [7:0]      lit,
  input logic [PG_W-1:0] page_sel,
  input logic [PC_W-1:0] pc,
  input logic [7:0]      w_val,
  input logic            w_load
);
  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> (pc == '1 && !w_load));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> pc == $past(pc) + {{(PC_W-1){1'b0}}, 1'b1});
  // R3
  far_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp && !inc) |=> pc == {$past(page_sel), $past(addr)});
  // R7
  w_load_chk: assert property (@(posedge clk) disable iff (rst)
    ret |=> (w_load && w_val == $past(lit)));
  // R7
  no_w_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ret |=> !w_load);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(inc || jmp || call || pcl_wr || ret) |=> $stable(pc));
endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_pc_seq.sv
`timescale 1ns/1ps
module sim_pc_seq;
  localparam int PC_W = 11;
  localparam int PG_W = PC_W - 9;

  logic clk = 1'b0;
  logic rst, inc, jmp, call, pcl_wr, ret;
  logic [8:0] addr;
  logic [7:0] lit;
  logic [PG_W-1:0] page_sel;
  logic [PC_W-1:0] pc;
  logic [7:0] w_val;
  logic w_load;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [PC_W-1:0] m_pc, m_s1, m_s2;
  logic [7:0] m_wv;
  logic m_wl;

  always #2 clk = ~clk;

  pc_seq #(.PC_W(PC_W)) u0 (.clk, .rst, .inc, .jmp, .call, .pcl_wr, .ret,
    .addr, .lit, .page_sel, .pc, .w_val, .w_load);

  task automatic chk(string req);
    n_chk++;
    if (pc !== m_pc || w_load !== m_wl || (m_wl && w_val !== m_wv)) begin
      n_fail++;
      $display("FAIL %s pc=%h wl=%b wv=%h exp pc=%h wl=%b wv=%h",
               req, pc, w_load, w_val, m_pc, m_wl, m_wv);
    end
  endtask

  // op: 0 none, 1 step, 2 jump, 3 call, 4 low write, 5 return, 6 reset, 7 reset with call
  task automatic op(int o, int a, int l, int pg, string req);
    @(negedge clk);
    rst = (o >= 6); inc = (o == 1); jmp = (o == 2);
    call = (o == 3 || o == 7); pcl_wr = (o == 4); ret = (o == 5);
    addr = 9'(a); lit = 8'(l); page_sel = PG_W'(pg);
    m_wl = 1'b0;
    case (o)
      1: m_pc = m_pc + 1'b1;
      2: m_pc = {PG_W'(pg), 9'(a)};
      3: begin m_s2 = m_s1; m_s1 = m_pc + 1'b1; m_pc = {PG_W'(pg), 1'b0, 8'(a)}; end
      4: m_pc = {PG_W'(pg), 1'b0, 8'(a)};
      5: begin m_pc = m_s1; m_s1 = m_s2; m_wl = 1'b1; m_wv = 8'(l); end
      6, 7: begin m_pc = '1; m_s1 = '0; m_s2 = '0; end
      default: ;
    endcase
    @(posedge clk); #1;
    chk(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 0; inc = 0; jmp = 0; call = 0; pcl_wr = 0; ret = 0;
    addr = 0; lit = 0; page_sel = 0; m_wv = 0;
    m_pc = '0; m_s1 = '0; m_s2 = '0;
    op(6, 0, 0, 0, "R1 reset vector");
    op(5, 0, 8'h5A, 0, "R1 empty stack return");
    op(6, 0, 0, 0, "R1");
    op(1, 0, 0, 0, "R2 wrap to zero");
    for (int i = 0; i < (1 << PC_W); i++) op(1, 0, 0, 0, "R2 sweep");
    op(2, 9'h1FF, 0, 0, "R3");
    op(1, 0, 0, 3, "R2 page carry");
    op(2, 9'h023, 0, 0, "R3 jump back to page 0");
    for (int p = 0; p < (1 << PG_W); p++)
      for (int a = 0; a < 512; a += 37) op(2, a, 0, p, "R3 sweep");
    op(0, 0, 0, 1, "R9 hold");
    op(4, 9'h1C4, 0, 2, "R5 low write");
    op(5, 0, 8'h11, 0, "R5 stack untouched");
    op(2, 9'h010, 0, 0, "R3");
    op(3, 9'h020, 0, 1, "R4 call A");
    op(3, 9'h130, 0, 2, "R4 call B");
    op(3, 9'h040, 0, 3, "R8 call C");
    op(5, 0, 8'hA1, 0, "R6 R7 ret 1");
    op(5, 0, 8'hA2, 0, "R8 ret 2");
    op(5, 0, 8'hA3, 0, "R6 ret 3 repeats");
    op(0, 0, 0, 0, "R7 no load");
    op(7, 9'h055, 0, 1, "R10 reset beats call");
    op(5, 0, 8'h77, 0, "R10 stack cleared");
    for (int i = 0; i < 4000; i++)
      op($urandom % 6, $urandom % 512, $urandom % 256, $urandom % (1 << PG_W),
         "R11 mixed");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule